// File: doc/BRIEF.md
# Prefix Field Indirection Unit

This block sits beside the issue stage of a processor whose register addresses are 9 bits wide. It watches the stream of issued instruction words. When it sees an indirection prefix, it works out a register address from the prefix's two operands. It then puts that address into exactly one field of the next issued instruction: the source field, the destination field, or the address the result is written to. Instruction memory is never touched. Only the pipeline copy of that one following instruction carries the new address.

The prefix also produces a write-back for its own destination register. The value written is the register's old value plus a signed 9-bit step, taken from bits 17 to 9 of the source operand. Software can therefore walk an array held in registers: the source operand gives the base and the step, and the destination register holds the running index. Each result of the block appears one clock after the instruction is issued. An interrupt shield stays high while a substitution is waiting to be used, so that nothing can come between a prefix and the instruction it modifies.

Top module: `pfx_indirect_unit`

## Requirements
- R1: An issued word is a prefix only when bits [27:21] equal 1001100 and bits [20:19] are not 11. The code in [20:19] picks the kind: 10 is source, 01 is destination, 00 is result. Any other word, including the 11 code, is a plain instruction that causes no write-back.
- R2: The substituted address is (S + D) mod 512. D is the prefix's `d_value`. S is the zero-extended 9-bit S field (bits [8:0]) when bit 18 (immediate flag) is 1, and `s_value` when bit 18 is 0.
- R3: After a source prefix, the next issued instruction has its S field replaced by the substituted address. Its D field and result address are unchanged.
- R4: After a destination prefix, the next issued instruction has its D field replaced. Its result address follows the new D field.
- R5: After a result prefix, only the result address of the next issued instruction is replaced. Its S and D fields are unchanged.
- R6: When no result prefix is pending, the result address equals the instruction's D field, after any D substitution.
- R7: A substitution applies to exactly one following issued instruction. Cycles with `issue_valid` low do not use it up. The instruction after the consuming one is passed unchanged, and `out_subst` marks the consuming instruction.
- R8: When a prefix's outputs appear, `wb_en` is 1, the write address is `out_r_addr`, and `wb_data` is `d_value` plus the sign-extended S[17:9]. For a plain instruction, `wb_en` is 0.
- R9: With an immediate S, S[17:9] is zero, so `wb_data` equals `d_value`. A step field of all ones (-1) decrements the index.
- R10: `irq_shield` is high from the clock in which a prefix's outputs appear until the outputs of the next issued instruction appear.
- R11: Field, write-back and flag outputs are registered and appear on the clock edge that captures the issued word. A synchronous reset clears `out_valid`, `wb_en`, `out_subst` and `irq_shield`, and drops any pending substitution.
- R12: A prefix issued right after another prefix has its own fields substituted by the first one. It then replaces the pending substitution with its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is issued this cycle |
| insn_word | input | 32 | Issued instruction word as fetched |
| d_value | input | 32 | Value read for the instruction's D register |
| s_value | input | 32 | Value read for the S register (used when not immediate) |
| out_valid | output | 1 | Registered outputs belong to an issued instruction |
| out_s_field | output | 9 | S field after substitution |
| out_d_field | output | 9 | D field after substitution |
| out_r_addr | output | 9 | Result write address after substitution |
| out_subst | output | 1 | This instruction consumed a pending substitution |
| wb_en | output | 1 | Prefix write-back to `out_r_addr` |
| wb_data | output | 32 | Post-incremented index value |
| irq_shield | output | 1 | Substitution pending; the next instruction is shielded |

## Verification
Every output of the block is due on the first rising edge after the issue inputs are applied, since one register stage sits between them. The pending substitution and the shield change on that same edge. The bench therefore drives each stimulus at a falling edge and compares all outputs at the next falling edge against a behavioural model. That model advances one issued word at a time. Idle cycles check that the shield holds and that nothing is consumed. Sequences with gaps between a prefix and its consumer, and with prefixes issued back to back, make the one-instruction lifetime of a substitution visible at the ports.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam int AW      = 9;
    localparam int IW      = 32;
    localparam int DW      = 32;
    localparam int S_LSB   = 0;
    localparam int D_LSB   = AW;
    localparam int IMM_POS = 2 * AW;
    localparam int SEL_LSB = 2 * AW + 1;
    localparam int OPC_LSB = 2 * AW + 3;
    localparam int OPC_W   = 7;
    localparam int NSLOT   = 2;

    localparam logic [OPC_W-1:0] ALT_OPCODE = 7'b1001100;

    typedef enum logic [1:0] {
        ALT_RES  = 2'b00,
        ALT_DST  = 2'b01,
        ALT_SRC  = 2'b10,
        ALT_NONE = 2'b11
    } alt_kind_e;

    typedef struct packed {
        logic [AW-1:0] r;
        logic [AW-1:0] d;
        logic [AW-1:0] s;
    } fields_t;

    function automatic alt_kind_e classify(input logic [IW-1:0] w);
        if (w[OPC_LSB +: OPC_W] == ALT_OPCODE && w[SEL_LSB +: 2] != 2'b11)
            return alt_kind_e'(w[SEL_LSB +: 2]);
        return ALT_NONE;
    endfunction

    function automatic logic [DW-1:0] step_of(input logic [DW-1:0] sop);
        return {{(DW-AW){sop[2*AW-1]}}, sop[2*AW-1:AW]};
    endfunction

    function automatic alt_kind_e slot_kind(input int g);
        return (g == 0) ? ALT_SRC : ALT_DST;
    endfunction

endpackage

// File: rtl/pfx_field_mux.sv
module pfx_field_mux
    import pfx_pkg::*;
(
    input  logic                pend_valid,
    input  alt_kind_e           pend_kind,
    input  logic [AW-1:0]       pend_addr,
    input  logic [2*AW-1:0]     insn_fields,
    output fields_t             fields
);

    logic [NSLOT-1:0][AW-1:0] slot_out;

    // Slot 0 is the S field, slot 1 the D field; each may take the pending address.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign slot_out[g] = (pend_valid && pend_kind == slot_kind(g))
                           ? pend_addr : insn_fields[g*AW +: AW];
    end

    always_comb begin
        fields.s = slot_out[0];
        fields.d = slot_out[1];
        fields.r = (pend_valid && pend_kind == ALT_RES) ? pend_addr : slot_out[1];
    end

endmodule

// File: rtl/pfx_operand.sv
module pfx_operand
    import pfx_pkg::*;
(
    input  logic          imm,
    input  logic [AW-1:0] s_field,
    input  logic [DW-1:0] s_value,
    input  logic [DW-1:0] d_value,
    output logic [AW-1:0] next_addr,
    output logic [DW-1:0] wb_value
);

    logic [DW-1:0] sop;

    always_comb begin
        sop       = imm ? {{(DW-AW){1'b0}}, s_field} : s_value;
        next_addr = sop[AW-1:0] + d_value[AW-1:0];
        wb_value  = d_value + step_of(sop);
    end

endmodule

// File: rtl/pfx_pending.sv
module pfx_pending
    import pfx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic          load,
    input  alt_kind_e     load_kind,
    input  logic [AW-1:0] load_addr,
    output logic          valid,
    output alt_kind_e     kind,
    output logic [AW-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            kind  <= ALT_NONE;
            addr  <= '0;
        end else if (advance) begin
            valid <= load;
            if (load) begin
                kind <= load_kind;
                addr <= load_addr;
            end
        end
    end

    // R7: a plain issued instruction consumes the pending substitution
    p_consume_once_r7: assert property (@(posedge clk) disable iff (rst)
        (advance && !load) |=> !valid);

    // R7: idle cycles leave the pending record alone
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(valid) && $stable(addr)));

    // R12: an issued prefix arms a fresh substitution with its own address
    p_rearm_r12: assert property (@(posedge clk) disable iff (rst)
        (advance && load) |=> (valid && addr == $past(load_addr)));

endmodule

// File: rtl/pfx_indirect_unit.sv
module pfx_indirect_unit
    import pfx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_valid,
    input  logic [IW-1:0] insn_word,
    input  logic [DW-1:0] d_value,
    input  logic [DW-1:0] s_value,
    output logic          out_valid,
    output logic [AW-1:0] out_s_field,
    output logic [AW-1:0] out_d_field,
    output logic [AW-1:0] out_r_addr,
    output logic          out_subst,
    output logic          wb_en,
    output logic [DW-1:0] wb_data,
    output logic          irq_shield
);

    logic          pend_valid;
    alt_kind_e     pend_kind;
    logic [AW-1:0] pend_addr;
    alt_kind_e     cur_kind;
    logic          cur_is_pfx;
    fields_t       cur_fields;
    logic [AW-1:0] cur_next_addr;
    logic [DW-1:0] cur_wb_value;

    always_comb begin
        cur_kind   = classify(insn_word);
        cur_is_pfx = (cur_kind != ALT_NONE);
    end

    pfx_field_mux u_mux (
        .pend_valid  (pend_valid),
        .pend_kind   (pend_kind),
        .pend_addr   (pend_addr),
        .insn_fields (insn_word[2*AW-1:0]),
        .fields      (cur_fields)
    );

    pfx_operand u_opnd (
        .imm       (insn_word[IMM_POS]),
        .s_field   (cur_fields.s),
        .s_value   (s_value),
        .d_value   (d_value),
        .next_addr (cur_next_addr),
        .wb_value  (cur_wb_value)
    );

    pfx_pending u_pend (
        .clk       (clk),
        .rst       (rst),
        .advance   (issue_valid),
        .load      (cur_is_pfx),
        .load_kind (cur_kind),
        .load_addr (cur_next_addr),
        .valid     (pend_valid),
        .kind      (pend_kind),
        .addr      (pend_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_subst   <= 1'b0;
            wb_en       <= 1'b0;
            out_s_field <= '0;
            out_d_field <= '0;
            out_r_addr  <= '0;
            wb_data     <= '0;
        end else begin
            out_valid <= issue_valid;
            out_subst <= issue_valid && pend_valid;
            wb_en     <= issue_valid && cur_is_pfx;
            if (issue_valid) begin
                out_s_field <= cur_fields.s;
                out_d_field <= cur_fields.d;
                out_r_addr  <= cur_fields.r;
                wb_data     <= cur_wb_value;
            end
        end
    end

    assign irq_shield = pend_valid;

    // R8: a write-back only ever accompanies a presented instruction
    p_wb_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> out_valid);

    // R10: an issued prefix raises the shield together with its outputs
    p_prefix_shields_r10: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && cur_is_pfx) |=> (irq_shield && wb_en));

    // R11: reset leaves nothing presented and nothing pending
    p_reset_state_r11: assert property (@(posedge clk)
        rst |=> (!out_valid && !irq_shield && !wb_en));

    // R6: with nothing consumed, the result address is the D field
    p_r_follows_d_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_subst) |-> (out_r_addr == out_d_field));

endmodule

// File: tb/pfx_indirect_unit_tb_top.sv
module pfx_indirect_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic [31:0] d_value = '0;
    logic [31:0] s_value = '0;
    logic        out_valid, out_subst, wb_en, irq_shield;
    logic [8:0]  out_s_field, out_d_field, out_r_addr;
    logic [31:0] wb_data;

    always #4 clk = ~clk;

    pfx_indirect_unit dut_i (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .insn_word(insn_word),
        .d_value(d_value), .s_value(s_value), .out_valid(out_valid),
        .out_s_field(out_s_field), .out_d_field(out_d_field), .out_r_addr(out_r_addr),
        .out_subst(out_subst), .wb_en(wb_en), .wb_data(wb_data), .irq_shield(irq_shield)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string phase = "R11";

    // behavioural model state
    bit          m_pend = 0;
    int          m_kind = 3;
    int          m_addr = 0;
    bit          e_valid = 0, e_subst = 0, e_wb = 0, e_sh = 0;
    int          e_s = 0, e_d = 0, e_r = 0;
    logic [31:0] e_wbd = '0;

    task automatic cmp(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s actual=%0h expected=%0h", req, phase, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        cmp("R11", "out_valid", out_valid, e_valid);
        cmp("R10", "irq_shield", irq_shield, e_sh);
        cmp("R8", "wb_en", wb_en, e_wb);
        if (e_valid) begin
            cmp("R3", "out_s_field", out_s_field, e_s);
            cmp("R4", "out_d_field", out_d_field, e_d);
            cmp("R5", "out_r_addr", out_r_addr, e_r);
            cmp("R7", "out_subst", out_subst, e_subst);
        end
        if (e_wb) cmp("R2", "wb_data", wb_data, e_wbd);
    endtask

    function automatic logic [31:0] mk(bit [6:0] opc, bit [1:0] sel, bit imm, int d, int s);
        logic [31:0] w;
        w = '0;
        w[31:28] = 4'hF;
        w[27:21] = opc;
        w[20:19] = sel;
        w[18]    = imm;
        w[17:9]  = d[8:0];
        w[8:0]   = s[8:0];
        return w;
    endfunction

    task automatic step(bit r, bit iv, logic [31:0] w, logic [31:0] dv, logic [31:0] sv);
        int s, d, st;
        logic [31:0] sop, sum;
        bit pfx;
        @(negedge clk);
        check_outputs();
        rst = r; issue_valid = iv; insn_word = w; d_value = dv; s_value = sv;
        if (r) begin
            m_pend = 0; e_valid = 0; e_subst = 0; e_wb = 0; e_sh = 0;
        end else if (!iv) begin
            e_valid = 0; e_subst = 0; e_wb = 0; e_sh = m_pend;
        end else begin
            s = int'(w[8:0]);
            d = int'(w[17:9]);
            if (m_pend && m_kind == 2) s = m_addr;
            if (m_pend && m_kind == 1) d = m_addr;
            e_r = (m_pend && m_kind == 0) ? m_addr : d;
            e_s = s; e_d = d;
            e_valid = 1; e_subst = m_pend;
            pfx = (w[27:21] == 7'b1001100) && (w[20:19] != 2'b11);
            e_wb = pfx;
            if (pfx) begin
                sop = w[18] ? 32'(s) : sv;
                st = int'(sop[17:9]);
                if (st >= 256) st = st - 512;
                e_wbd = dv + 32'(st);
                sum = sop + dv;
                m_addr = int'(sum[8:0]);
                m_kind = int'(w[20:19]);
                m_pend = 1;
            end else begin
                m_pend = 0;
            end
            e_sh = m_pend;
        end
    endtask

    localparam bit [6:0] OPC = 7'b1001100;

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        for (int i = 0; i < 3; i++) step(1, 1, mk(OPC, 2'b10, 1, 3, 4), 32'h5, 32'h0);
        step(1, 0, '0, '0, '0);

        // R1: non-prefix words, including the 11 kind code
        phase = "R1";
        step(0, 1, mk(7'b1001101, 2'b10, 0, 7, 8), 32'h10, 32'h200);
        step(0, 1, mk(OPC, 2'b11, 1, 7, 8), 32'h10, 32'h200);
        step(0, 1, mk(7'b0000000, 2'b00, 0, 1, 2), 32'h1, 32'h1);

        // R2 R3: source prefix with register S, step +1 and wrap of the sum
        phase = "R3";
        step(0, 1, mk(OPC, 2'b10, 0, 20, 0), 32'h0000_0105, {14'd0, 9'd1, 9'h1F0});
        step(0, 1, mk(7'h11, 2'b00, 0, 33, 44), 32'h0, 32'h0);
        step(0, 1, mk(7'h11, 2'b00, 0, 33, 44), 32'h0, 32'h0);

        // R4: destination prefix, result follows the new D
        phase = "R4";
        step(0, 1, mk(OPC, 2'b01, 0, 21, 0), 32'h0000_0003, {14'd0, 9'd2, 9'h040});
        step(0, 1, mk(7'h22, 2'b01, 0, 100, 101), 32'h0, 32'h0);

        // R5: result prefix, S and D untouched
        phase = "R5";
        step(0, 1, mk(OPC, 2'b00, 0, 22, 0), 32'h0000_0010, {14'd0, 9'd0, 9'h080});
        step(0, 1, mk(7'h33, 2'b10, 0, 150, 151), 32'h0, 32'h0);
        phase = "R6";
        step(0, 1, mk(7'h33, 2'b10, 0, 152, 153), 32'h0, 32'h0);

        // R9: immediate S gives no step; step of -1 decrements
        phase = "R9";
        step(0, 1, mk(OPC, 2'b10, 1, 23, 9'h1FF), 32'h0000_0042, 32'hFFFF_FFFF);
        step(0, 1, mk(7'h44, 2'b00, 0, 5, 6), 32'h0, 32'h0);
        step(0, 1, mk(OPC, 2'b01, 0, 24, 0), 32'h0000_0000, {14'd0, 9'h1FF, 9'h010});
        step(0, 1, mk(7'h44, 2'b00, 0, 5, 6), 32'h0, 32'h0);

        // R7 R10: idle gaps neither consume nor drop the substitution
        phase = "R7";
        step(0, 1, mk(OPC, 2'b10, 1, 25, 9'h030), 32'h0000_0004, 32'h0);
        step(0, 0, '0, '0, '0);
        step(0, 0, '0, '0, '0);
        step(0, 1, mk(7'h55, 2'b00, 0, 60, 61), 32'h0, 32'h0);
        step(0, 1, mk(7'h55, 2'b00, 0, 62, 63), 32'h0, 32'h0);

        // R12: back-to-back prefixes chain
        phase = "R12";
        step(0, 1, mk(OPC, 2'b10, 1, 26, 9'h005), 32'h0000_0001, 32'h0);
        step(0, 1, mk(OPC, 2'b01, 1, 27, 9'h000), 32'h0000_0100, 32'h0);
        step(0, 1, mk(7'h66, 2'b00, 0, 70, 71), 32'h0, 32'h0);

        // mixed random traffic
        phase = "R7";
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom_range(0, 2) == 0) w[27:21] = OPC;
            step(0, ($urandom_range(0, 4) != 0), w, $urandom, $urandom);
        end

        // R11: reset in the middle of a pending substitution
        phase = "R11";
        step(0, 1, mk(OPC, 2'b00, 1, 28, 9'h011), 32'h2, 32'h0);
        step(1, 0, '0, '0, '0);
        step(0, 1, mk(7'h77, 2'b00, 0, 80, 81), 32'h0, 32'h0);
        step(0, 0, '0, '0, '0);
        @(negedge clk);
        check_outputs();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule